// File: doc/BRIEF.md
# Successive Approximation Conversion Engine

This block is the digital control for a successive-approximation converter with a sample-and-hold front end. A start pulse begins a conversion. The block first runs a sample window of a fixed number of cycles. It then decides the result one bit per step, from the most significant bit down. During each step it drives a trial code to an external DAC and comparator, and it reads a one-bit comparator decision back at the end of that step. The DAC, the comparator and the input multiplexer are outside the block.

The total conversion length is fixed. When the last bit has been decided early, the engine waits out the remaining cycles, so the done pulse always comes at the same distance from the start. A mode input chooses between a full 10-bit result and a short 8-bit result. The mode is captured when a conversion is accepted. The result is held on its output until the next conversion completes or a reset occurs.

Top module: `sar_engine`

## Requirements
- R1: While and directly after a synchronous reset (`rst` high), `busy_o`, `sample_o` and `done_o` are 0, and `dac_code_o` and `result_o` are all zeros.
- R2: With the engine idle, a cycle with `start_i` high is accepted at that clock edge. `sample_o` is then high for exactly 60 cycles, beginning in the cycle right after the accepting edge, and only while `busy_o` is high.
- R3: `busy_o` is high for 98 cycles, starting in the cycle right after the accepting edge. `done_o` is then high for exactly one cycle, the 99th cycle after the accepting edge, and `busy_o` is 0 in that cycle.
- R4: When the sample window closes, `dac_code_o` shows a trial code that has only bit 9 set. Each trial step lasts 3 cycles. In step t, the bits above position 9-t hold their earlier decisions and bit 9-t is set as the candidate.
- R5: A comparator input `comp_i` of 1 at the end of a step keeps the candidate bit, and 0 clears it. With mode 0 (10-bit), `result_o[9:0]` is the decided 10-bit code.
- R6: With mode 1 (8-bit), only bits 9 down to 2 are tried. `dac_code_o[1:0]` stays 0 throughout, and `result_o` carries the decided bits right-aligned in bits 7..0, with bits 9..8 equal to 0.
- R7: `res8_i` is captured at the accepting edge. Changing it during a conversion has no effect on that conversion's trials or result.
- R8: A `start_i` pulse while `busy_o` is high is ignored. It does not restart or shift the conversion in progress.
- R9: `result_o` changes only in the cycle where `done_o` is high, or through reset.
- R10: A reset during a conversion aborts it. No `done_o` follows, and the outputs return to the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Conversion request, taken only while idle |
| res8_i | input | 1 | Resolution select: 0 = 10-bit, 1 = 8-bit |
| comp_i | input | 1 | Comparator decision for the current trial code: 1 = keep candidate |
| busy_o | output | 1 | Conversion in progress |
| sample_o | output | 1 | Sample-and-hold window active |
| dac_code_o | output | 10 | Trial code driven to the DAC |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 10 | Converted value, held between conversions |

## Verification
The bound checker counts busy cycles itself. On every cycle it checks that the sample window covers exactly the first 60 of them and that done lands on the 98-cycle mark as a single pulse with busy low. It also checks that the first trial code after sampling has only the top bit set, that the two low DAC bits stay clear in 8-bit mode, and that the result holds still between done pulses. The bench drives an ideal threshold comparator over every 10-bit input level, and over 256 input levels in 8-bit mode. Only these scenarios can show that each trial code carries the right prefix, that the final value equals the input level, that a mode change or a second start in mid-conversion is ignored, and that a reset in mid-conversion aborts the conversion.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SAMPLE,
    PH_TRIAL,
    PH_SETTLE
  } sar_phase_e;

endpackage

// File: rtl/sar_timer.sv
module sar_timer
  import sar_pkg::*;
#(
  parameter int FULL_BITS     = 10,
  parameter int SHORT_BITS    = 8,
  parameter int SAMPLE_CYCLES = 60,
  parameter int TOTAL_CYCLES  = 98,
  parameter int STEP_CYCLES   = 3,
  localparam int CNT_W  = $clog2(TOTAL_CYCLES + 1),
  localparam int SUB_W  = $clog2(STEP_CYCLES + 1),
  localparam int STEP_W = $clog2(FULL_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic              res8_i,
  output sar_phase_e        phase_o,
  output logic              load_o,
  output logic              decide_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o,
  output logic              finish_o
);

  sar_phase_e        phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [SUB_W-1:0]  sub_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_step;

  // Index of the final trial step for the captured resolution
  always_comb begin
    if (res8_i) last_step = STEP_W'(SHORT_BITS - 1);
    else        last_step = STEP_W'(FULL_BITS - 1);
  end

  assign load_o   = (phase_q == PH_SAMPLE) && (cnt_q == CNT_W'(SAMPLE_CYCLES));
  assign decide_o = (phase_q == PH_TRIAL) && (sub_q == SUB_W'(STEP_CYCLES - 1));
  assign last_o   = (step_q == last_step);
  assign finish_o = (phase_q != PH_IDLE) && (cnt_q == CNT_W'(TOTAL_CYCLES));
  assign phase_o  = phase_q;
  assign step_o   = step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sub_q   <= '0;
      step_q  <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (go_i) begin
            phase_q <= PH_SAMPLE;
            cnt_q   <= CNT_W'(1);
          end
        end
        PH_SAMPLE: begin
          cnt_q <= cnt_q + 1'b1;
          if (load_o) begin
            phase_q <= PH_TRIAL;
            sub_q   <= '0;
            step_q  <= '0;
          end
        end
        PH_TRIAL: begin
          cnt_q <= cnt_q + 1'b1;
          if (decide_o) begin
            sub_q <= '0;
            if (last_o) phase_q <= PH_SETTLE;
            else        step_q  <= step_q + 1'b1;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        default: begin
          cnt_q <= cnt_q + 1'b1;
        end
      endcase
      if (finish_o) begin
        phase_q <= PH_IDLE;
        cnt_q   <= '0;
      end
    end
  end

endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
  parameter int FULL_BITS  = 10,
  parameter int SHORT_BITS = 8,
  localparam int STEP_W = $clog2(FULL_BITS + 1),
  localparam int LOW    = FULL_BITS - SHORT_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_i,
  input  logic                 load_i,
  input  logic                 decide_i,
  input  logic                 last_i,
  input  logic [STEP_W-1:0]    step_i,
  input  logic                 comp_i,
  input  logic                 res8_i,
  input  logic                 finish_i,
  output logic [FULL_BITS-1:0] code_o,
  output logic [FULL_BITS-1:0] result_o
);

  logic [FULL_BITS-1:0] code_q;
  logic [FULL_BITS-1:0] result_q;
  logic [FULL_BITS-1:0] trial_sel;
  logic [FULL_BITS-1:0] next_sel;

  // One-hot selection of the bit under trial and of the one below it
  always_comb begin
    for (int i = 0; i < FULL_BITS; i++) begin
      trial_sel[i] = (int'(step_i) == FULL_BITS - 1 - i);
      next_sel[i]  = (int'(step_i) == FULL_BITS - 2 - i);
    end
  end

  for (genvar i = 0; i < FULL_BITS; i++) begin : g_bit
    localparam logic IS_TOP = (i == FULL_BITS - 1);
    always_ff @(posedge clk) begin
      if (rst || clear_i) begin
        code_q[i] <= 1'b0;
      end else if (load_i) begin
        code_q[i] <= IS_TOP;
      end else if (decide_i) begin
        if (trial_sel[i])                code_q[i] <= comp_i;
        else if (next_sel[i] && !last_i) code_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q <= '0;
    end else if (finish_i) begin
      if (res8_i) result_q <= code_q >> LOW;
      else        result_q <= code_q;
    end
  end

  assign code_o   = code_q;
  assign result_o = result_q;

endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int FULL_BITS     = 10,
  parameter int SHORT_BITS    = 8,
  parameter int SAMPLE_CYCLES = 60,
  parameter int TOTAL_CYCLES  = 98,
  parameter int STEP_CYCLES   = 3,
  localparam int STEP_W = $clog2(FULL_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 res8_i,
  input  logic                 comp_i,
  output logic                 busy_o,
  output logic                 sample_o,
  output logic [FULL_BITS-1:0] dac_code_o,
  output logic                 done_o,
  output logic [FULL_BITS-1:0] result_o
);

  sar_phase_e        phase;
  logic              go;
  logic              mode_q;
  logic              done_q;
  logic              load;
  logic              decide;
  logic              last;
  logic              finish;
  logic [STEP_W-1:0] step;

  assign go = start_i && (phase == PH_IDLE);

  // Resolution captured once per conversion
  always_ff @(posedge clk) begin
    if (rst)     mode_q <= 1'b0;
    else if (go) mode_q <= res8_i;
  end

  always_ff @(posedge clk) begin
    if (rst) done_q <= 1'b0;
    else     done_q <= finish;
  end

  sar_timer #(
    .FULL_BITS    (FULL_BITS),
    .SHORT_BITS   (SHORT_BITS),
    .SAMPLE_CYCLES(SAMPLE_CYCLES),
    .TOTAL_CYCLES (TOTAL_CYCLES),
    .STEP_CYCLES  (STEP_CYCLES)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .go_i    (go),
    .res8_i  (mode_q),
    .phase_o (phase),
    .load_o  (load),
    .decide_o(decide),
    .last_o  (last),
    .step_o  (step),
    .finish_o(finish)
  );

  sar_approx_reg #(
    .FULL_BITS (FULL_BITS),
    .SHORT_BITS(SHORT_BITS)
  ) u_sreg (
    .clk     (clk),
    .rst     (rst),
    .clear_i (go),
    .load_i  (load),
    .decide_i(decide),
    .last_i  (last),
    .step_i  (step),
    .comp_i  (comp_i),
    .res8_i  (mode_q),
    .finish_i(finish),
    .code_o  (dac_code_o),
    .result_o(result_o)
  );

  assign busy_o   = (phase != PH_IDLE);
  assign sample_o = (phase == PH_SAMPLE);
  assign done_o   = done_q;

endmodule

// File: rtl/sar_engine_chk.sv
module sar_engine_chk #(
  parameter int FULL_BITS     = 10,
  parameter int SHORT_BITS    = 8,
  parameter int SAMPLE_CYCLES = 60,
  parameter int TOTAL_CYCLES  = 98,
  localparam int CNT_W = $clog2(TOTAL_CYCLES + 2),
  localparam int LOW   = FULL_BITS - SHORT_BITS,
  localparam logic [FULL_BITS-1:0] TOP_ONLY = FULL_BITS'(1) << (FULL_BITS - 1),
  localparam logic [FULL_BITS-1:0] LOW_MASK = (FULL_BITS'(1) << LOW) - FULL_BITS'(1)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busy_o,
  input logic                 sample_o,
  input logic                 done_o,
  input logic [FULL_BITS-1:0] dac_code_o,
  input logic [FULL_BITS-1:0] result_o,
  input logic                 mode_q
);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy_o) busy_cnt <= '0;
    else                busy_cnt <= busy_cnt + 1'b1;
  end

  assert_sample_window_R2: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (sample_o == (int'(busy_cnt) < SAMPLE_CYCLES)));

  assert_sample_in_busy_R2: assert property (@(posedge clk) disable iff (rst)
    sample_o |-> busy_o);

  assert_done_timing_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (int'(busy_cnt) == TOTAL_CYCLES));

  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  assert_busy_ends_done_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy_o) && !$past(rst)) |-> done_o);

  assert_first_trial_R4: assert property (@(posedge clk) disable iff (rst)
    ($fell(sample_o) && !$past(rst)) |-> (dac_code_o == TOP_ONLY));

  assert_short_low_clear_R6: assert property (@(posedge clk) disable iff (rst)
    mode_q |-> ((dac_code_o & LOW_MASK) == '0));

  assert_short_aligned_R6: assert property (@(posedge clk) disable iff (rst)
    (done_o && mode_q) |-> ((result_o >> SHORT_BITS) == '0));

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!done_o && !$past(rst)) |-> $stable(result_o));

endmodule

bind sar_engine sar_engine_chk #(
  .FULL_BITS    (FULL_BITS),
  .SHORT_BITS   (SHORT_BITS),
  .SAMPLE_CYCLES(SAMPLE_CYCLES),
  .TOTAL_CYCLES (TOTAL_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy_o    (busy_o),
  .sample_o  (sample_o),
  .done_o    (done_o),
  .dac_code_o(dac_code_o),
  .result_o  (result_o),
  .mode_q    (mode_q)
);

// File: tb/sar_engine_tb.sv
module sar_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       res8_i = 1'b0;
  logic       comp_i;
  logic       busy_o;
  logic       sample_o;
  logic [9:0] dac_code_o;
  logic       done_o;
  logic [9:0] result_o;
  logic [9:0] vin = '0;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  ended = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Ideal threshold comparator: keep the candidate while the code does not exceed the input level
  assign comp_i = (dac_code_o <= vin);

  sar_engine u_dut (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .res8_i    (res8_i),
    .comp_i    (comp_i),
    .busy_o    (busy_o),
    .sample_o  (sample_o),
    .dac_code_o(dac_code_o),
    .done_o    (done_o),
    .result_o  (result_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    check(busy_o == 1'b0,   req, int'(busy_o), 0);
    check(sample_o == 1'b0, req, int'(sample_o), 0);
    check(done_o == 1'b0,   req, int'(done_o), 0);
    check(dac_code_o == '0, req, int'(dac_code_o), 0);
    check(result_o == '0,   req, int'(result_o), 0);
  endtask

  // One conversion; observations at the k-th falling edge after start was raised
  task automatic run_conv(input logic [9:0] v, input bit m8, input bit spur);
    int nb = m8 ? 8 : 10;
    int done_at = 0;
    int done_cnt = 0;
    int s_cnt = 0;
    int s_first = 0;
    int code_bad = 0;
    int bad_val = 0;
    int bad_exp = 0;
    int busy98 = 0;
    int busy99 = 1;
    int res99 = 0;
    int res100 = 0;
    int exp_res = m8 ? int'(v >> 2) : int'(v);
    vin = v;
    res8_i = m8;
    start_i = 1'b1;
    for (int k = 1; k <= 100; k++) begin
      @(negedge clk);
      if (k == 1) start_i = 1'b0;
      if (k == 30) res8_i = !m8;
      if (spur && k == 40) start_i = 1'b1;
      if (spur && k == 41) start_i = 1'b0;
      if (sample_o) begin
        s_cnt++;
        if (s_first == 0) s_first = k;
      end
      if (done_o) begin
        done_cnt++;
        if (done_at == 0) done_at = k;
      end
      if (k >= 61) begin
        int t = (k - 61) / 3;
        if (t < nb) begin
          int mask = 1024 - (1 << (10 - t));
          int exp_code = (int'(v) & mask) | (1 << (9 - t));
          if (int'(dac_code_o) != exp_code) begin
            if (code_bad == 0) begin
              bad_val = int'(dac_code_o);
              bad_exp = exp_code;
            end
            code_bad++;
          end
        end
      end
      if (k == 98) busy98 = int'(busy_o);
      if (k == 99) begin
        busy99 = int'(busy_o);
        res99 = int'(result_o);
      end
      if (k == 100) res100 = int'(result_o);
    end
    res8_i = m8;
    // R2: sample window length and placement
    check(s_cnt == 60 && s_first == 1, "R2", s_cnt * 1000 + s_first, 60 * 1000 + 1);
    // R3 / R8: done lands at the 99th observation, once, even with a spurious start
    check(done_at == 99 && done_cnt == 1, spur ? "R8" : "R3", done_at, 99);
    check(busy98 == 1 && busy99 == 0, "R3", busy98 * 10 + busy99, 10);
    // R4 / R6 / R7: trial code prefix and candidate per step
    check(code_bad == 0, m8 ? "R6" : "R4", bad_val, bad_exp);
    // R5 / R6 / R7: final value
    check(res99 == exp_res, m8 ? "R6" : "R5", res99, exp_res);
    // R9: held after done
    check(res100 == exp_res, "R9", res100, exp_res);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_idle("R1");
    rst = 1'b0;
    @(negedge clk);
    check_idle("R1");

    // R5 / R7 / R8: every 10-bit input level
    for (int v = 0; v < 1024; v++) begin
      run_conv(10'(v), 1'b0, (v % 5) == 0);
    end

    // R6 / R7 / R8: 256 input levels in 8-bit mode
    for (int j = 0; j < 256; j++) begin
      run_conv(10'(j * 4 + (j % 4)), 1'b1, (j % 7) == 0);
    end

    // R10: reset during a conversion aborts it
    vin = 10'd700;
    res8_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (48) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R10");
    begin
      int seen = 0;
      for (int k = 0; k < 110; k++) begin
        @(negedge clk);
        if (done_o || busy_o) seen++;
      end
      check(seen == 0, "R10", seen, 0);
    end

    // R5 after the abort: a normal conversion still completes
    run_conv(10'd1023, 1'b0, 1'b0);
    run_conv(10'd0, 1'b1, 1'b0);

    if (!ended) begin
      ended = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog: actual %0d expected %0d", WATCHDOG, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule